// File: doc/BRIEF.md
# Start-up Charging Controller

This block lets a completely flat battery be charged with no processor running. It watches three comparator flags: the battery is under the low master-reset threshold, the battery is over the high master-reset threshold, and the charger voltage is over its detection threshold. When a charger is plugged in while the battery is under the low threshold, the block turns on a constant-current enable. The enable stands for a 100 mA source outside this block. Charging stops when the battery climbs past the high threshold. At that point the block raises a master-reset release that hands control to the power-up sequencer.

The flags come from analog comparators and change with no relation to the clock. Each one goes through a two-flop synchronizer before it is used. Charging is started by an edge, not a level. If the battery collapses under the low threshold again during a charge, the charge is cancelled. After that, only a new plug-in edge can start it again. A charger that stays connected does not restart it.

Top module: `boot_charge_ctrl`

## Requirements
- R1: During and right after reset, `cc_en` and `rst_release` are both 0.
- R2: A 0-to-1 change of `chg_det_a` while `bat_low_a` is 1 sets `cc_en` to 1 on the third rising clock edge after the change, and not on an earlier edge.
- R3: A 0-to-1 change of `chg_det_a` while `bat_low_a` is 0 leaves `cc_en` at 0.
- R4: While charging, `bat_high_a` going to 1 clears `cc_en` and sets `rst_release` to 1 on the third rising edge after the change.
- R5: `rst_release` stays at 1 until `bat_low_a` goes back to 1; three rising edges after that, it returns to 0.
- R6: While charging, a 0-to-1 change of `bat_low_a` cancels the charge (`cc_en` goes to 0 three edges later). A 1-to-0 change of `bat_low_a` has no effect on the charge.
- R7: After a cancel or a release, a `chg_det_a` level that stays at 1 never restarts charging. Only a new 0-to-1 change of `chg_det_a` while `bat_low_a` is 1 restarts it.
- R8: While charging, `chg_det_a` going to 0 returns the block to idle, and `cc_en` goes to 0 three edges later.
- R9: `cc_en` and `rst_release` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bat_low_a | input | 1 | Asynchronous flag: battery under the low master-reset threshold |
| bat_high_a | input | 1 | Asynchronous flag: battery over the high master-reset threshold |
| chg_det_a | input | 1 | Asynchronous flag: charger voltage over the detection threshold |
| cc_en | output | 1 | Constant-current charge enable |
| rst_release | output | 1 | Master-reset release to the power-up sequencer |

## Verification
Every result is due on the third rising edge after an input change:
- two edges to pass the synchronizer;
- one edge to load the state register, with the edge detector working combinationally on the synchronized value.

The bench changes inputs on falling edges, counts rising edges, and samples on the falling edge after the third. For the start case it also samples after the second edge, to show the enable has not yet changed. For ignored stimuli and held levels, the bench waits well past three edges before it samples the outputs.

// File: rtl/boot_charge_pkg.sv
// Package: shared state encoding and flag indexes for the start-up charging controller.
// Assumes: the flag vector is packed in the order given by the index parameters.
package boot_charge_pkg;

    localparam int FLAG_W   = 3;
    localparam int IDX_LOW  = 0;
    localparam int IDX_HIGH = 1;
    localparam int IDX_CHG  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHARGE = 2'd1,
        ST_DONE   = 2'd2
    } chg_state_t;

endpackage

// File: rtl/bc_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous flags.
// Assumes: each bit is an independent level; no relation between bits is kept.
module bc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    // Purpose: first capture stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Purpose: further settling stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bc_edge.sv
// Module: rising-edge detector for a vector of synchronized flags.
// Assumes: inputs are already synchronous; after reset, a flag that is already high counts as a rise.
module bc_edge #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev;

    // Purpose: remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // Purpose: flag a 0-to-1 change.
    always_comb rise = lvl & ~prev;
endmodule

// File: rtl/bc_fsm.sv
// Module: state machine for edge-armed start-up charging.
// Assumes: synchronized levels and rise pulses come in on the same cycle.
// The battery-high check takes priority over a charger drop, which takes priority over a cancel.
module bc_fsm
    import boot_charge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic low_s,
    input  logic high_s,
    input  logic chg_s,
    input  logic low_rise,
    input  logic chg_rise,
    output logic cc_en,
    output logic rst_release
);
    chg_state_t state, state_nx;

    // Purpose: next-state decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (chg_rise && low_s) state_nx = ST_CHARGE;
            end
            ST_CHARGE: begin
                if (high_s)        state_nx = ST_DONE;
                else if (!chg_s)   state_nx = ST_IDLE;
                else if (low_rise) state_nx = ST_IDLE;
            end
            ST_DONE: begin
                if (low_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Purpose: decode outputs from the state.
    always_comb begin
        cc_en       = (state == ST_CHARGE);
        rst_release = (state == ST_DONE);
    end
endmodule

// File: rtl/boot_charge_ctrl.sv
// Module: top of the start-up charging controller.
// Assumes: the three comparator flags are asynchronous. Every result is due three clock edges after a flag changes.
module boot_charge_ctrl
    import boot_charge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bat_low_a,
    input  logic bat_high_a,
    input  logic chg_det_a,
    output logic cc_en,
    output logic rst_release
);
    logic [FLAG_W-1:0] flags_a, flags_s, flags_r;
    logic low_s, high_s, chg_s, low_rise, chg_rise;

    // Purpose: pack the raw flags in index order.
    always_comb begin
        flags_a           = '0;
        flags_a[IDX_LOW]  = bat_low_a;
        flags_a[IDX_HIGH] = bat_high_a;
        flags_a[IDX_CHG]  = chg_det_a;
    end

    bc_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(flags_a), .q_sync(flags_s)
    );

    bc_edge #(.WIDTH(FLAG_W)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(flags_s), .rise(flags_r)
    );

    // Purpose: unpack the synchronized levels and edges.
    always_comb begin
        low_s    = flags_s[IDX_LOW];
        high_s   = flags_s[IDX_HIGH];
        chg_s    = flags_s[IDX_CHG];
        low_rise = flags_r[IDX_LOW];
        chg_rise = flags_r[IDX_CHG];
    end

    bc_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .low_s(low_s), .high_s(high_s), .chg_s(chg_s),
        .low_rise(low_rise), .chg_rise(chg_rise),
        .cc_en(cc_en), .rst_release(rst_release)
    );
endmodule

// File: rtl/boot_charge_ctrl_chk.sv
// Module: property checker for boot_charge_ctrl, attached by bind.
// Assumes: it sees the synchronized levels and edge pulses inside the top.
module boot_charge_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cc_en,
    input logic rst_release,
    input logic low_s,
    input logic high_s,
    input logic chg_s,
    input logic low_rise,
    input logic chg_rise
);
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc_en && rst_release)); // R9
    AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_en) |-> $past(low_s)); // R2
    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_en) |-> $past(chg_rise)); // R7
    AST_RELEASE_FROM_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_release) |-> ($past(cc_en) && $past(high_s))); // R4
    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_release && !low_s) |=> rst_release); // R5
    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && low_rise && !high_s) |=> !cc_en); // R6
    AST_CHARGER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && !chg_s && !high_s) |=> !cc_en); // R8
endmodule

bind boot_charge_ctrl boot_charge_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cc_en(cc_en), .rst_release(rst_release),
    .low_s(low_s), .high_s(high_s), .chg_s(chg_s),
    .low_rise(low_rise), .chg_rise(chg_rise)
);

// File: tb/boot_charge_ctrl_tb_top.sv
module boot_charge_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bat_low_a = 1'b0, bat_high_a = 1'b0, chg_det_a = 1'b0;
    logic cc_en, rst_release;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    boot_charge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bat_low_a(bat_low_a), .bat_high_a(bat_high_a),
        .chg_det_a(chg_det_a), .cc_en(cc_en), .rst_release(rst_release)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Wait n rising edges, then settle on the next falling edge.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 cc_en in reset", cc_en, 1'b0);
        check("R1 release in reset", rst_release, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        edges(4);
        check("R1 cc_en after reset", cc_en, 1'b0);
        check("R1 release after reset", rst_release, 1'b0);
    endtask

    task automatic t_start_and_drop;
        bat_low_a = 1'b1; edges(4);
        chg_det_a = 1'b1;
        edges(2);
        check("R2 cc_en not before third edge", cc_en, 1'b0);
        edges(1);
        check("R2 cc_en on third edge", cc_en, 1'b1);
        chg_det_a = 1'b0; edges(3);
        check("R8 charger drop idles", cc_en, 1'b0);
        edges(4);
    endtask

    task automatic t_ignore_when_not_low;
        bat_low_a = 1'b0; edges(4);
        chg_det_a = 1'b1; edges(6);
        check("R3 edge with battery not low", cc_en, 1'b0);
        bat_low_a = 1'b1; edges(6);
        check("R7 level after battery drop", cc_en, 1'b0);
        chg_det_a = 1'b0; edges(4);
    endtask

    task automatic t_complete;
        chg_det_a = 1'b1; edges(3);
        check("R2 restart charge", cc_en, 1'b1);
        bat_low_a = 1'b0; edges(5);
        check("R6 falling low flag keeps charge", cc_en, 1'b1);
        bat_high_a = 1'b1; edges(3);
        check("R4 release asserted", rst_release, 1'b1);
        check("R4 cc_en cleared", cc_en, 1'b0);
        bat_high_a = 1'b0; edges(6);
        check("R5 release held", rst_release, 1'b1);
        bat_low_a = 1'b1; edges(3);
        check("R5 release cleared", rst_release, 1'b0);
        edges(10);
        check("R7 no restart after release", cc_en, 1'b0);
    endtask

    task automatic t_cancel;
        chg_det_a = 1'b0; edges(4);
        chg_det_a = 1'b1; edges(3);
        check("R2 charge before cancel", cc_en, 1'b1);
        bat_low_a = 1'b0; edges(4);
        bat_low_a = 1'b1; edges(3);
        check("R6 cancel on collapse", cc_en, 1'b0);
        check("R9 no release on cancel", rst_release, 1'b0);
        edges(20);
        check("R7 held level no restart", cc_en, 1'b0);
        chg_det_a = 1'b0; edges(4);
        chg_det_a = 1'b1; edges(3);
        check("R7 fresh edge restarts", cc_en, 1'b1);
        check("R9 release low while charging", rst_release, 1'b0);
        chg_det_a = 1'b0; edges(4);
    endtask

    initial begin
        edges(3);
        t_reset();
        t_start_and_drop();
        t_ignore_when_not_low();
        t_complete();
        t_cancel();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule